// File: doc/BRIEF.md
# Parity-Protected Two-Port RAM

This block is a 256-entry memory of 9-bit words with one write port and one read port. The read port can fetch a word in the same cycle that another word is being written. Both ports use active-low controls: a strobe and a port select. Build-time parameters choose the timing of each port. The write port is either clocked or strobe-edge driven. The read port is one of three kinds: combinational, registered with one cycle of latency (transparent), or registered with two cycles of latency (pipelined).

The ninth bit of each word carries parity, and the sense comes from a run-time input: high selects odd, low selects even. A build-time parameter picks one of two parity modes. In generate mode, the block replaces the top bit of each written word with a freshly computed parity bit. In check mode, it stores words as given and flags any word whose nine bits break the selected sense. It does this on the write side for incoming words and on the read side for words being delivered.

Top module: `ptram_top`

## Requirements
- R1: The array holds 256 words of 9 bits, addressed by 8-bit addresses. With a clocked write port, a write takes place at the rising write-clock edge only when `wr_stb_n` and `wr_sel_n` are both 0. A later read of that address returns the stored word.
- R2: A write attempt with either `wr_stb_n` or `wr_sel_n` at 1 leaves every stored word unchanged.
- R3: With the strobe-driven write port, a word is stored on the rising edge of `wr_stb_n` if `wr_sel_n` is 0 at that moment. If `wr_sel_n` is 1, nothing is stored.
- R4: With the transparent read kind, `rd_data` shows the word at `rd_addr` just after the rising read-clock edge on which `rd_stb_n` and `rd_sel_n` are both 0 (one cycle of latency).
- R5: With the pipelined read kind, the same word appears one read-clock edge later than with the transparent kind (two cycles of latency).
- R6: On a registered read port, `rd_data` and `rd_perr` keep their values through edges on which no read is enabled.
- R7: With the combinational read kind, `rd_data` follows `rd_addr` while the read is enabled, and reads 0 when `rd_stb_n` or `rd_sel_n` is 1.
- R8: In generate mode, bit 8 of each stored word is replaced by parity over bits 7..0. It is chosen so that the count of ones in the 9 bits is odd when `par_odd` = 1 and even when `par_odd` = 0.
- R9: In check mode, `rd_perr` accompanies `rd_data`. It is 1 exactly when the delivered 9-bit word has an even count of ones under `par_odd` = 1, or an odd count under `par_odd` = 0. `par_odd` is taken at the moment the word is read.
- R10: In check mode, `wr_perr` is 1 exactly while a write is enabled and `wr_data` breaks the selected sense. In generate mode, `wr_perr` and `rd_perr` stay 0.
- R11: When a clocked write and a registered read hit the same address on the same edge, the read returns the word held before the write.
- R12: While reset is asserted, and after it is released, a registered read port shows `rd_data` = 0 and `rd_perr` = 0 until its first enabled read.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock (used when the write port is clocked) |
| rd_clk | input | 1 | Read clock (used by registered read kinds) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `rd_clk` |
| par_odd | input | 1 | Parity sense: 1 selects odd, 0 selects even |
| wr_addr | input | 8 | Write address |
| wr_data | input | 9 | Write word (bit 8 is parity) |
| wr_stb_n | input | 1 | Write strobe, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| wr_perr | output | 1 | Parity error on the incoming word (check mode) |
| rd_addr | input | 8 | Read address |
| rd_stb_n | input | 1 | Read strobe, active low |
| rd_sel_n | input | 1 | Read port select, active low |
| rd_data | output | 9 | Read word |
| rd_perr | output | 1 | Parity error on the delivered word (check mode) |

## Verification
The clocked properties assume several things about the inputs. The read strobe, select and address are settled before each rising read-clock edge. The read and write clocks are one and the same. For the strobe-driven write port, the address, data and select are steady across the rising edge of the write strobe. The stimulus follows these rules: all clocked inputs change only at falling clock edges, and each strobe-driven write moves the strobe low and then high with the address, data and select held steady on both sides of the rise. Address ranges are narrowed at random so that reads and writes often collide, which also covers the same-address, same-edge case.

// File: rtl/ptram_pkg.sv
package ptram_pkg;

  // Read-port timing variants.
  typedef enum logic [1:0] {
    RD_COMB = 2'd0,   // combinational read
    RD_REG1 = 2'd1,   // one register stage after the array
    RD_REG2 = 2'd2    // two register stages after the array
  } rd_kind_e;

  // Parity handling variants.
  typedef enum logic {
    PAR_MAKE = 1'b0,  // replace top bit on write
    PAR_TEST = 1'b1   // keep word, flag mismatches
  } par_kind_e;

  // Parity bit that completes a word whose other bits reduce to red_xor.
  function automatic logic make_bit(input logic red_xor, input logic odd);
    return odd ? ~red_xor : red_xor;
  endfunction

  // True when a whole word reducing to red_xor breaks the chosen sense.
  function automatic logic sense_bad(input logic red_xor, input logic odd);
    return odd ? ~red_xor : red_xor;
  endfunction

endpackage

// File: rtl/ptram_rst_sync.sv
module ptram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/ptram_wr_port.sv
module ptram_wr_port
  import ptram_pkg::*;
#(
  parameter int        DW  = 9,
  parameter par_kind_e PAR = PAR_MAKE
) (
  input  logic [DW-1:0] wr_data,
  input  logic          wr_stb_n,
  input  logic          wr_sel_n,
  input  logic          par_odd,
  output logic          wr_go,
  output logic [DW-1:0] wr_word,
  output logic          wr_perr
);

  localparam int PB = DW - 1;

  always_comb begin
    wr_go = ~wr_stb_n & ~wr_sel_n;
  end

  generate
    if (PAR == PAR_MAKE) begin : g_make
      logic low_xor;
      logic wr_unused_pbit;
      always_comb begin
        low_xor = ^wr_data[PB-1:0];
        wr_word = {make_bit(low_xor, par_odd), wr_data[PB-1:0]};
        wr_perr = 1'b0;
      end
      assign wr_unused_pbit = wr_data[PB];
    end else begin : g_test
      logic full_xor;
      always_comb begin
        full_xor = ^wr_data;
        wr_word  = wr_data;
        wr_perr  = wr_go & sense_bad(full_xor, par_odd);
      end
    end
  endgenerate

endmodule

// File: rtl/ptram_array.sv
module ptram_array #(
  parameter int AW         = 8,
  parameter int DW         = 9,
  parameter bit WR_CLOCKED = 1'b1
) (
  input  logic          wr_clk,
  input  logic          wr_go,
  input  logic          wr_stb_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_word,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  generate
    if (WR_CLOCKED) begin : g_clocked
      logic arr_unused_strobe;
      always_ff @(posedge wr_clk) begin
        if (wr_go) begin
          mem_q[wr_addr] <= wr_word;
        end
      end
      assign arr_unused_strobe = wr_stb_n ^ wr_sel_n;
    end else begin : g_strobed
      logic arr_unused_clk;
      // The word is captured when the strobe returns high.
      always_ff @(posedge wr_stb_n) begin
        if (!wr_sel_n) begin
          mem_q[wr_addr] <= wr_word;
        end
      end
      assign arr_unused_clk = wr_clk ^ wr_go;
    end
  endgenerate

  assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/ptram_rd_port.sv
module ptram_rd_port
  import ptram_pkg::*;
#(
  parameter int        DW   = 9,
  parameter rd_kind_e  KIND = RD_REG1,
  parameter par_kind_e PAR  = PAR_MAKE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb_n,
  input  logic          rd_sel_n,
  input  logic          par_odd,
  input  logic [DW-1:0] mem_word,
  output logic [DW-1:0] rd_data,
  output logic          rd_perr
);

  typedef struct packed {
    logic          perr;
    logic [DW-1:0] data;
  } rd_slot_t;

  logic     fire;
  rd_slot_t fresh;

  always_comb begin
    fire       = ~rd_stb_n & ~rd_sel_n;
    fresh.data = mem_word;
    fresh.perr = (PAR == PAR_TEST) ? sense_bad(^mem_word, par_odd) : 1'b0;
  end

  generate
    if (KIND == RD_COMB) begin : g_comb
      logic rd_unused_clk;
      always_comb begin
        rd_data = fire ? fresh.data : '0;
        rd_perr = fire & fresh.perr;
      end
      assign rd_unused_clk = clk ^ rst_n;
    end else begin : g_reg
      rd_slot_t s1_q;
      rd_slot_t s1_d;

      always_comb begin
        s1_d = s1_q;
        if (fire) begin
          s1_d = fresh;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= '0;
        end else begin
          s1_q <= s1_d;
        end
      end

      if (KIND == RD_REG1) begin : g_one
        always_comb begin
          rd_data = s1_q.data;
          rd_perr = s1_q.perr;
        end

        AST_RD_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
          !fire |=> ($stable(rd_data) && $stable(rd_perr)))
          else $error("read output moved without a read"); // R6
        AST_RD_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
          fire |=> (rd_data == $past(mem_word)))
          else $error("transparent read returned wrong word"); // R4
      end else begin : g_two
        rd_slot_t s2_q;
        rd_slot_t s2_d;
        logic     s1_vld_q;
        logic     s1_vld_d;

        always_comb begin
          s1_vld_d = fire;
          s2_d     = s2_q;
          if (s1_vld_q) begin
            s2_d = s1_q;
          end
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            s1_vld_q <= 1'b0;
            s2_q     <= '0;
          end else begin
            s1_vld_q <= s1_vld_d;
            s2_q     <= s2_d;
          end
        end

        always_comb begin
          rd_data = s2_q.data;
          rd_perr = s2_q.perr;
        end

        AST_RD_HOLD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
          !s1_vld_q |=> ($stable(rd_data) && $stable(rd_perr)))
          else $error("pipelined output moved without a read"); // R6
        AST_RD_LOAD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
          fire |=> ##1 (rd_data == $past(mem_word, 2)))
          else $error("pipelined read returned wrong word"); // R5
      end
    end
  endgenerate

endmodule

// File: rtl/ptram_top.sv
module ptram_top
  import ptram_pkg::*;
#(
  parameter int        AW         = 8,
  parameter int        DW         = 9,
  parameter bit        WR_CLOCKED = 1'b1,
  parameter rd_kind_e  RD_KIND    = RD_REG1,
  parameter par_kind_e PAR_KIND   = PAR_MAKE
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          par_odd,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_stb_n,
  input  logic          wr_sel_n,
  output logic          wr_perr,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_stb_n,
  input  logic          rd_sel_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_perr
);

  logic          rd_rst_n;
  logic          wr_go;
  logic [DW-1:0] wr_word;
  logic [DW-1:0] arr_word;

  ptram_rst_sync u_rst_sync (
    .clk     (rd_clk),
    .arst_n  (rst_n),
    .rst_n_o (rd_rst_n)
  );

  ptram_wr_port #(
    .DW  (DW),
    .PAR (PAR_KIND)
  ) u_wr_port (
    .wr_data  (wr_data),
    .wr_stb_n (wr_stb_n),
    .wr_sel_n (wr_sel_n),
    .par_odd  (par_odd),
    .wr_go    (wr_go),
    .wr_word  (wr_word),
    .wr_perr  (wr_perr)
  );

  ptram_array #(
    .AW         (AW),
    .DW         (DW),
    .WR_CLOCKED (WR_CLOCKED)
  ) u_array (
    .wr_clk   (wr_clk),
    .wr_go    (wr_go),
    .wr_stb_n (wr_stb_n),
    .wr_sel_n (wr_sel_n),
    .wr_addr  (wr_addr),
    .wr_word  (wr_word),
    .rd_addr  (rd_addr),
    .rd_word  (arr_word)
  );

  ptram_rd_port #(
    .DW   (DW),
    .KIND (RD_KIND),
    .PAR  (PAR_KIND)
  ) u_rd_port (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n),
    .rd_stb_n (rd_stb_n),
    .rd_sel_n (rd_sel_n),
    .par_odd  (par_odd),
    .mem_word (arr_word),
    .rd_data  (rd_data),
    .rd_perr  (rd_perr)
  );

  AST_WPE_QUALIFIED: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_perr |-> (!wr_stb_n && !wr_sel_n))
    else $error("write parity flag without an enabled write"); // R10

  generate
    if (WR_CLOCKED && PAR_KIND == PAR_MAKE) begin : g_gen_chk
      AST_GEN_STORE_OK: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_go |-> (par_odd ? (^wr_word) : ~(^wr_word)))
        else $error("generated word breaks parity sense"); // R8
    end
  endgenerate

endmodule

// File: tb/ptram_top_tb_top.sv
`timescale 1ns/1ps
module ptram_top_tb_top;
  import ptram_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       par_odd;
  logic [7:0] wr_addr, rd_addr;
  logic [8:0] wr_data;
  logic       wr_stb_n, wr_sel_n, rd_stb_n, rd_sel_n;
  logic [8:0] a_rd_data, b_rd_data;
  logic       a_rd_perr, b_rd_perr, a_wr_perr, b_wr_perr;

  logic [7:0] c_wr_addr, c_rd_addr;
  logic [8:0] c_wr_data, c_rd_data;
  logic       c_wr_stb_n, c_wr_sel_n, c_rd_stb_n, c_rd_sel_n;
  logic       c_wr_perr, c_rd_perr;

  // Clocked write, transparent read, parity generated.
  ptram_top #(.WR_CLOCKED(1'b1), .RD_KIND(RD_REG1), .PAR_KIND(PAR_MAKE)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .par_odd(par_odd),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb_n(wr_stb_n), .wr_sel_n(wr_sel_n),
    .wr_perr(a_wr_perr), .rd_addr(rd_addr), .rd_stb_n(rd_stb_n), .rd_sel_n(rd_sel_n),
    .rd_data(a_rd_data), .rd_perr(a_rd_perr));

  // Clocked write, pipelined read, parity checked.
  ptram_top #(.WR_CLOCKED(1'b1), .RD_KIND(RD_REG2), .PAR_KIND(PAR_TEST)) dut_pipe_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .par_odd(par_odd),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb_n(wr_stb_n), .wr_sel_n(wr_sel_n),
    .wr_perr(b_wr_perr), .rd_addr(rd_addr), .rd_stb_n(rd_stb_n), .rd_sel_n(rd_sel_n),
    .rd_data(b_rd_data), .rd_perr(b_rd_perr));

  // Strobe-driven write, combinational read, parity checked.
  ptram_top #(.WR_CLOCKED(1'b0), .RD_KIND(RD_COMB), .PAR_KIND(PAR_TEST)) dut_comb_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .par_odd(par_odd),
    .wr_addr(c_wr_addr), .wr_data(c_wr_data), .wr_stb_n(c_wr_stb_n), .wr_sel_n(c_wr_sel_n),
    .wr_perr(c_wr_perr), .rd_addr(c_rd_addr), .rd_stb_n(c_rd_stb_n), .rd_sel_n(c_rd_sel_n),
    .rd_data(c_rd_data), .rd_perr(c_rd_perr));

  logic [8:0] mem_a [256];
  logic [8:0] mem_b [256];
  logic [8:0] mem_c [256];
  logic [8:0] ea_data, eb_data, b_s1_data;
  logic       ea_perr, eb_perr, b_s1_perr, b_s1_v;
  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [8:0] make_word(input logic [8:0] d, input logic odd);
    logic p;
    p = ^d[7:0];
    return {odd ? ~p : p, d[7:0]};
  endfunction

  function automatic logic bad_word(input logic [8:0] w, input logic odd);
    return odd ? ~(^w) : (^w);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One clock cycle for the two clocked instances; entered and left at a falling edge.
  task automatic ab_cycle(input logic [7:0] wa, input logic [8:0] wd, input logic wsn,
                          input logic wssn, input logic [7:0] ra, input logic rsn,
                          input logic rssn, input logic odd, input string tag);
    logic rfire, wfire, exp_wpe;
    string ta, tb, tp;
    wr_addr = wa; wr_data = wd; wr_stb_n = wsn; wr_sel_n = wssn;
    rd_addr = ra; rd_stb_n = rsn; rd_sel_n = rssn; par_odd = odd;
    rfire = !rsn && !rssn;
    wfire = !wsn && !wssn;
    #1;
    exp_wpe = wfire && bad_word(wd, odd);
    check(a_wr_perr == 1'b0, "R10", "generate-mode wr_perr", int'(a_wr_perr), 0);
    check(b_wr_perr == exp_wpe, "R10", "check-mode wr_perr", int'(b_wr_perr), int'(exp_wpe));
    @(posedge clk);
    if (b_s1_v) begin
      eb_data = b_s1_data;
      eb_perr = b_s1_perr;
    end
    b_s1_v = rfire;
    if (rfire) begin
      b_s1_data = mem_b[ra];
      b_s1_perr = bad_word(mem_b[ra], odd);
      ea_data   = mem_a[ra];
      ea_perr   = 1'b0;
    end
    if (wfire) begin
      mem_a[wa] = make_word(wd, odd);
      mem_b[wa] = wd;
    end
    @(negedge clk);
    ta = (tag != "") ? tag : (rfire ? "R4" : "R6");
    tb = (tag != "") ? tag : "R5";
    tp = (tag != "") ? tag : "R9";
    check(a_rd_data == ea_data, ta, "transparent rd_data", int'(a_rd_data), int'(ea_data));
    check(a_rd_perr == ea_perr, "R10", "generate-mode rd_perr", int'(a_rd_perr), int'(ea_perr));
    check(b_rd_data == eb_data, tb, "pipelined rd_data", int'(b_rd_data), int'(eb_data));
    check(b_rd_perr == eb_perr, tp, "pipelined rd_perr", int'(b_rd_perr), int'(eb_perr));
  endtask

  task automatic ab_idle(input string tag);
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, par_odd, tag);
  endtask

  task automatic c_write(input logic [7:0] a, input logic [8:0] d, input logic seln,
                         input logic odd, input string tag);
    logic exp;
    c_wr_addr = a; c_wr_data = d; c_wr_sel_n = seln; par_odd = odd;
    #1;
    c_wr_stb_n = 1'b0;
    #1;
    exp = !seln && bad_word(d, odd);
    check(c_wr_perr == exp, "R10", "strobe-port wr_perr", int'(c_wr_perr), int'(exp));
    #1;
    c_wr_stb_n = 1'b1;
    #1;
    c_wr_sel_n = 1'b1;
    if (!seln) mem_c[a] = d;
    if (tag != "") begin
      // tag kept for call-site documentation
    end
  endtask

  task automatic c_read(input logic [7:0] a, input logic stbn, input logic seln,
                        input logic odd, input string tag);
    logic [8:0] exp_d;
    logic exp_p;
    logic fire;
    c_rd_addr = a; c_rd_stb_n = stbn; c_rd_sel_n = seln; par_odd = odd;
    fire = !stbn && !seln;
    #1;
    exp_d = fire ? mem_c[a] : 9'h000;
    exp_p = fire && bad_word(mem_c[a], odd);
    check(c_rd_data == exp_d, tag, "combinational rd_data", int'(c_rd_data), int'(exp_d));
    check(c_rd_perr == exp_p, (tag == "R7") ? "R7" : "R9", "combinational rd_perr",
          int'(c_rd_perr), int'(exp_p));
    c_rd_stb_n = 1'b1; c_rd_sel_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; par_odd = 1'b1;
    wr_addr = '0; wr_data = '0; wr_stb_n = 1'b1; wr_sel_n = 1'b1;
    rd_addr = '0; rd_stb_n = 1'b1; rd_sel_n = 1'b1;
    c_wr_addr = '0; c_wr_data = '0; c_wr_stb_n = 1'b1; c_wr_sel_n = 1'b1;
    c_rd_addr = '0; c_rd_stb_n = 1'b1; c_rd_sel_n = 1'b1;
    ea_data = '0; ea_perr = 1'b0; eb_data = '0; eb_perr = 1'b0;
    b_s1_data = '0; b_s1_perr = 1'b0; b_s1_v = 1'b0;

    repeat (3) @(negedge clk);
    check(a_rd_data == 9'h000, "R12", "rd_data in reset (transparent)", int'(a_rd_data), 0);
    check(a_rd_perr == 1'b0, "R12", "rd_perr in reset (transparent)", int'(a_rd_perr), 0);
    check(b_rd_data == 9'h000, "R12", "rd_data in reset (pipelined)", int'(b_rd_data), 0);
    check(b_rd_perr == 1'b0, "R12", "rd_perr in reset (pipelined)", int'(b_rd_perr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(a_rd_data == 9'h000, "R12", "rd_data after reset", int'(a_rd_data), 0);
    check(b_rd_perr == 1'b0, "R12", "rd_perr after reset", int'(b_rd_perr), 0);

    // Fill every address so later reads see known words.
    for (int i = 0; i < 256; i++) begin
      ab_cycle(8'(i), 9'($urandom), 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'($urandom), "R1");
    end

    // R1: read back a filled address through both read kinds.
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'd10, 1'b0, 1'b0, 1'b1, "R1");
    ab_idle("R1");

    // R11: same address written and read on one edge returns the old word.
    ab_cycle(8'd20, 9'h0aa, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0, 1'b1, "R11");
    ab_idle("R11");
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'd20, 1'b0, 1'b0, 1'b1, "R11");
    ab_idle("R11");

    // R2: strobe or select high blocks the write.
    ab_cycle(8'd30, 9'h1ff, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, "R2");
    ab_cycle(8'd30, 9'h155, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R2");
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'd30, 1'b0, 1'b0, 1'b1, "R2");
    ab_idle("R2");

    // R8: generated parity bit under both senses.
    ab_cycle(8'd40, 9'h000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R8");
    ab_cycle(8'd41, 9'h103, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R8");
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'd40, 1'b0, 1'b0, 1'b1, "R8");
    check(a_rd_data == 9'h100, "R8", "odd-sense word for 0x00", int'(a_rd_data), 9'h100);
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'd41, 1'b0, 1'b0, 1'b0, "R8");
    check(a_rd_data == 9'h003, "R8", "even-sense word for 0x03", int'(a_rd_data), 9'h003);
    ab_idle("R8");

    // R9: the same stored word passes one sense and fails the other.
    ab_cycle(8'd50, 9'h001, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R9");
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'd50, 1'b0, 1'b0, 1'b1, "R9");
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'd50, 1'b0, 1'b0, 1'b0, "R9");
    check(b_rd_perr == 1'b0, "R9", "odd-sense clean word", int'(b_rd_perr), 0);
    ab_idle("R9");
    check(b_rd_perr == 1'b1, "R9", "even-sense flagged word", int'(b_rd_perr), 1);

    // R6: outputs hold while the read address moves with no read enabled.
    ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'd60, 1'b0, 1'b0, 1'b1, "R6");
    for (int k = 0; k < 3; k++) begin
      ab_cycle(8'h00, 9'h000, 1'b1, 1'b1, 8'(61 + k), 1'b1, 1'b0, 1'b0, "R6");
    end

    // Constrained random traffic with frequent address overlap.
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] wa, ra;
      wa = ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom);
      ra = ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom);
      ab_cycle(wa, 9'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 4 == 0),
               ra, 1'($urandom % 3 == 0), 1'($urandom % 4 == 0), 1'($urandom), "");
    end

    // Strobe-driven write, combinational read instance.
    for (int i = 0; i < 256; i++) begin
      c_write(8'(i), 9'($urandom), 1'b0, 1'($urandom), "R3");
    end
    c_read(8'd5, 1'b0, 1'b0, 1'b1, "R3");
    c_write(8'd70, 9'h155, 1'b0, 1'b1, "R3");
    c_write(8'd70, 9'h0aa, 1'b1, 1'b1, "R3");
    c_read(8'd70, 1'b0, 1'b0, 1'b1, "R3");
    check(c_rd_data == 9'h000, "R7", "combinational idle output", int'(c_rd_data), 0);
    c_read(8'd70, 1'b1, 1'b0, 1'b1, "R7");
    c_read(8'd70, 1'b0, 1'b1, 1'b0, "R7");
    c_read(8'd70, 1'b0, 1'b0, 1'b0, "R7");
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 2) begin
        c_write(8'($urandom % 32), 9'($urandom), 1'($urandom % 4 == 0), 1'($urandom), "R3");
      end else begin
        c_read(8'($urandom % 32), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
               1'($urandom), "R7");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule